// File: doc/BRIEF.md
# BCD Retriggerable Watchdog Countdown Timer

This block counts down a programmed interval in 10 ms steps and signals software when that interval runs out without a service write. The interval is held in two byte-wide load registers in packed BCD. One holds the fractional part (tenths and hundredths), the other the whole seconds (tens and units), so the range is 00.01 s to 99.99 s. A single-cycle enable pulse at 100 Hz, made elsewhere, advances the count.

Any write to either load register restarts the countdown from the full programmed value. Firmware keeps writing one of them to hold off a timeout. When the count runs out, a sticky expiry flag is set and the count reloads at once, so expiries repeat at the programmed period. A control register holds a mask bit and a routing bit, and exposes the flag, which a read of that register clears. The unmasked flag drives one of two active-high interrupt lines, chosen by the routing bit. A load value of 00.00 parks the counter.

Top module: `wdt_bcd_watchdog`

## Requirements
- R1: After reset, both load registers and the control register read 0x00 and both interrupt outputs are low.
- R2: Register map. Address 0 is the fractional load byte (tenths in bits 7:4, hundredths in bits 3:0). Address 1 is the seconds load byte (tens in bits 7:4, units in bits 3:0). Address 2 is control: bit 0 is the expiry flag (read-only), bit 1 is the mask, bit 2 is the route. Other control bits read 0, and address 3 reads 0x00.
- R3: A written BCD nibble above 9 is stored as 9.
- R4: A write to address 0 or 1 restarts the countdown. The first expiry comes on exactly the Nth tick after that write, where N = 1000·tens + 100·units + 10·tenths + hundredths.
- R5: After an expiry the count reloads without software action, and the next expiry comes exactly N ticks later.
- R6: With a load value of 00.00, no number of ticks sets the flag.
- R7: An expiry sets the flag. The flag stays set until a read of address 2, which returns it as 1 and then clears it.
- R8: If an expiry and a read of address 2 fall in the same cycle, the read returns the old flag value and the flag ends up set.
- R9: If a load register write falls in the same cycle as the tick that would expire the count, the restart wins and the flag is not set.
- R10: An interrupt is driven only while the flag is 1 and the mask is 0. With route 0 it goes to irq_a, with route 1 to irq_b, and the other line stays low. Masking does not clear the flag.
- R11: The count is decremented in BCD, borrowing across digits and across the two bytes, so 00.10, 01.00 and 99.99 expire after 10, 100 and 9999 ticks.
- R12: A write to address 2 does not restart or disturb the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 100 Hz count enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flag when it reads address 2) |
| addr | input | ADDR_W | Register address |
| wdata | input | DIG_PER_REG*4 | Write data |
| rdata | output | DIG_PER_REG*4 | Combinational read data for addr |
| irq_a | output | 1 | Interrupt line for route 0 |
| irq_b | output | 1 | Interrupt line for route 1 |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the expiring tick and a flag-clearing control read. The second is the expiring tick and a restarting load write. Each pair is provoked by running the count to one tick before expiry, then driving the tick together with the read or the write. In the read case, the returned value must show the old flag and the flag must be set afterwards. In the write case, the flag must stay clear, and a full new period must elapse before the next expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DIG_W      = 4;
  localparam int CTRL_FLAG  = 0;
  localparam int CTRL_MASK  = 1;
  localparam int CTRL_ROUTE = 2;

  // Clamp a BCD digit into 0..9.
  function automatic logic [DIG_W-1:0] bcd_digit_sat(input logic [DIG_W-1:0] d);
    return (d > 4'd9) ? 4'd9 : d;
  endfunction

  // One-step BCD digit decrement with wrap 0 -> 9.
  function automatic logic [DIG_W-1:0] bcd_digit_dec(input logic [DIG_W-1:0] d);
    return (d == 4'd0) ? 4'd9 : d - 4'd1;
  endfunction
endpackage

// File: rtl/wdt_load_regs.sv
module wdt_load_regs
  import wdt_pkg::*;
#(
  parameter int NREG        = 2,
  parameter int DIG_PER_REG = 2,
  parameter int ADDR_W      = 2,
  localparam int REG_W      = DIG_PER_REG * DIG_W,
  localparam int LOAD_W     = NREG * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [LOAD_W-1:0] load_val,
  output logic [LOAD_W-1:0] load_next,
  output logic              restart
);
  logic [REG_W-1:0] wsat;
  logic [NREG-1:0]  wsel;

  for (genvar j = 0; j < DIG_PER_REG; j++) begin : g_sat
    assign wsat[j*DIG_W +: DIG_W] = bcd_digit_sat(wdata[j*DIG_W +: DIG_W]);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [REG_W-1:0] store_q;
    assign wsel[i] = wr_en && (addr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)       store_q <= '0;
      else if (wsel[i]) store_q <= wsat;
    end
    assign load_val[i*REG_W +: REG_W]  = store_q;
    assign load_next[i*REG_W +: REG_W] = wsel[i] ? wsat : store_q;
  end

  assign restart = |wsel;
endmodule

// File: rtl/wdt_bcd_counter.sv
module wdt_bcd_counter
  import wdt_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int CW  = NDIG * DIG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] load_next,
  output logic [CW-1:0] count,
  output logic          active,
  output logic          expire
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0]   count_q;
  logic [CW-1:0]   dec_val;
  logic [NDIG-1:0] borrow;

  assign borrow[0] = 1'b1;
  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [DIG_W-1:0] d;
    assign d = count_q[g*DIG_W +: DIG_W];
    assign dec_val[g*DIG_W +: DIG_W] = borrow[g] ? bcd_digit_dec(d) : d;
    if (g < NDIG - 1) begin : g_chain
      assign borrow[g+1] = borrow[g] && (d == '0);
    end
  end

  assign active = (load_val != '0);
  assign expire = tick && !restart && active && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)              count_q <= '0;
    else if (restart)        count_q <= load_next;
    else if (expire)         count_q <= load_val;
    else if (tick && active) count_q <= dec_val;
  end

  assign count = count_q;
endmodule

// File: rtl/wdt_ctrl_irq.sv
module wdt_ctrl_irq #(
  parameter int ADDR_W                  = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_mask,
  input  logic              wr_route,
  input  logic              expire,
  output logic              flag,
  output logic              mask,
  output logic              route,
  output logic              flag_clr,
  output logic              irq_a,
  output logic              irq_b
);
  logic ctrl_sel;
  logic irq_live;

  assign ctrl_sel = (addr == CTRL_ADDR);
  assign flag_clr = rd_en && ctrl_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask  <= 1'b0;
      route <= 1'b0;
    end else if (wr_en && ctrl_sel) begin
      mask  <= wr_mask;
      route <= wr_route;
    end
  end

  // Expiry outranks the read-clear so no event is lost.
  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (expire)   flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  assign irq_live = flag && !mask;
  assign irq_a    = irq_live && !route;
  assign irq_b    = irq_live && route;
endmodule

// File: rtl/wdt_bcd_watchdog.sv
module wdt_bcd_watchdog
  import wdt_pkg::*;
#(
  parameter int NREG        = 2,
  parameter int DIG_PER_REG = 2,
  parameter int ADDR_W      = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tick,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DIG_PER_REG*DIG_W-1:0]   wdata,
  output logic [DIG_PER_REG*DIG_W-1:0]   rdata,
  output logic                           irq_a,
  output logic                           irq_b
);
  localparam int REG_W  = DIG_PER_REG * DIG_W;
  localparam int NDIG   = NREG * DIG_PER_REG;
  localparam int LOAD_W = NDIG * DIG_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NREG);

  logic [LOAD_W-1:0] load_val, load_next, count;
  logic restart, active, expire;
  logic flag, mask, route, flag_clr;
  logic [REG_W-1:0] ctrl_word;

  wdt_load_regs #(.NREG(NREG), .DIG_PER_REG(DIG_PER_REG), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .load_val(load_val), .load_next(load_next), .restart(restart)
  );

  wdt_bcd_counter #(.NDIG(NDIG)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
    .load_val(load_val), .load_next(load_next),
    .count(count), .active(active), .expire(expire)
  );

  wdt_ctrl_irq #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_mask(wdata[CTRL_MASK]), .wr_route(wdata[CTRL_ROUTE]), .expire(expire),
    .flag(flag), .mask(mask), .route(route), .flag_clr(flag_clr),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  always_comb begin
    ctrl_word             = '0;
    ctrl_word[CTRL_FLAG]  = flag;
    ctrl_word[CTRL_MASK]  = mask;
    ctrl_word[CTRL_ROUTE] = route;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == ADDR_W'(i)) rdata = load_val[i*REG_W +: REG_W];
    end
    if (addr == CTRL_ADDR) rdata = ctrl_word;
  end
endmodule

// File: rtl/wdt_bcd_watchdog_checker.sv
module wdt_bcd_watchdog_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          expire,
  input logic          active,
  input logic          flag,
  input logic          mask,
  input logic          flag_clr,
  input logic          irq_a,
  input logic          irq_b,
  input logic [CW-1:0] count,
  input logic [CW-1:0] load_val,
  input logic [CW-1:0] load_next
);
  for (genvar g = 0; g < CW/4; g++) begin : g_bcd
    assert_count_digit_bcd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      count[g*4 +: 4] <= 4'd9);
  end

  assert_restart_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == $past(load_next));

  assert_reload_after_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == $past(load_val));

  assert_zero_load_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !expire);

  assert_expiry_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  assert_read_clears_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !expire) |=> !flag);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && expire) |=> flag);

  assert_restart_beats_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !expire);

  assert_irq_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_a, irq_b}));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a || irq_b) |-> (flag && !mask));
endmodule

bind wdt_bcd_watchdog wdt_bcd_watchdog_checker #(.CW(LOAD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .restart(restart), .expire(expire), .active(active),
  .flag(flag), .mask(mask), .flag_clr(flag_clr), .irq_a(irq_a), .irq_b(irq_b),
  .count(count), .load_val(load_val), .load_next(load_next)
);

// File: tb/wdt_bcd_watchdog_tb_top.sv
module wdt_bcd_watchdog_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_a, irq_b;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  wdt_bcd_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ticks_of(input logic [7:0] secs, input logic [7:0] frac);
    return int'(secs[7:4]) * 1000 + int'(secs[3:0]) * 100
         + int'(frac[7:4]) * 10 + int'(frac[3:0]);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic load(input logic [7:0] secs, input logic [7:0] frac);
    wr(2'd1, secs);
    wr(2'd0, frac);
  endtask

  task automatic test_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 frac", d, 0);
    rd(2'd1, d); chk("R1 secs", d, 0);
    rd(2'd2, d); chk("R1 ctrl", d, 0);
    chk("R1 irq_a", irq_a, 0);
    chk("R1 irq_b", irq_b, 0);
  endtask

  task automatic test_map_sat();
    logic [7:0] d;
    wr(2'd0, 8'h3A); rd(2'd0, d); chk("R3 low nibble clamp", d, 8'h39);
    wr(2'd1, 8'hF5); rd(2'd1, d); chk("R3 high nibble clamp", d, 8'h95);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R2 ctrl bits", d, 8'h06);
    rd(2'd3, d); chk("R2 unmapped", d, 0);
    wr(2'd2, 8'h00);
  endtask

  task automatic test_period(input logic [7:0] secs, input logic [7:0] frac, input string req);
    logic [7:0] d;
    int n;
    n = ticks_of(secs, frac);
    load(secs, frac);
    for (int rep = 0; rep < 2; rep++) begin
      run_ticks(n - 1);
      chk({req, " no early expiry"}, irq_a, 0);
      run_ticks(1);
      chk({req, " expiry on tick N"}, irq_a, 1);
      rd(2'd2, d); chk("R7 flag reads 1", d[0], 1);
      rd(2'd2, d); chk("R7 flag cleared", d[0], 0);
      if (rep == 0) req = "R5";
    end
  endtask

  task automatic test_zero();
    logic [7:0] d;
    load(8'h00, 8'h00);
    run_ticks(300);
    chk("R6 irq", irq_a, 0);
    rd(2'd2, d); chk("R6 flag", d[0], 0);
  endtask

  task automatic test_retrigger();
    load(8'h00, 8'h20);
    run_ticks(15);
    wr(2'd0, 8'h20);
    run_ticks(19);
    chk("R4 retrigger holds off", irq_a, 0);
    run_ticks(1);
    chk("R4 expiry after retrigger", irq_a, 1);
    begin logic [7:0] d; rd(2'd2, d); end
  endtask

  task automatic test_write_vs_expiry();
    load(8'h00, 8'h04);
    run_ticks(3);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'h04;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    chk("R9 no flag on restart", irq_a, 0);
    run_ticks(3);
    chk("R9 full new period", irq_a, 0);
    run_ticks(1);
    chk("R9 expiry after period", irq_a, 1);
    begin logic [7:0] d; rd(2'd2, d); end
  endtask

  task automatic test_read_vs_expiry();
    logic [7:0] d;
    load(8'h00, 8'h03);
    run_ticks(2);
    @(negedge clk); tick = 1'b1; rd_en = 1'b1; addr = 2'd2;
    #1 d = rdata;
    @(negedge clk); tick = 1'b0; rd_en = 1'b0;
    chk("R8 read sees old flag", d[0], 0);
    chk("R8 flag survives", irq_a, 1);
    rd(2'd2, d); chk("R8 flag set", d[0], 1);
  endtask

  task automatic test_mask_route();
    logic [7:0] d;
    load(8'h00, 8'h05);
    run_ticks(3);
    wr(2'd2, 8'h00);
    run_ticks(2);
    chk("R12 ctrl write keeps count", irq_a, 1);
    wr(2'd2, 8'h02);
    chk("R10 masked a", irq_a, 0);
    chk("R10 masked b", irq_b, 0);
    wr(2'd2, 8'h04);
    chk("R10 route b", irq_b, 1);
    chk("R10 route b a low", irq_a, 0);
    wr(2'd2, 8'h00);
    chk("R10 route a", irq_a, 1);
    rd(2'd2, d); chk("R10 mask kept flag", d[0], 1);
    load(8'h00, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_map_sat();
    test_period(8'h00, 8'h05, "R4");
    test_period(8'h00, 8'h10, "R11 00.10");
    test_period(8'h01, 8'h00, "R11 01.00");
    test_period(8'h99, 8'h99, "R11 99.99");
    test_zero();
    test_retrigger();
    test_write_vs_expiry();
    test_read_vs_expiry();
    test_mask_route();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule